// File: doc/BRIEF.md
# SDRAM Command Issuer

This block sits between a memory controller's scheduler and the SDRAM pins. Each cycle it takes at most one abstract request: an operation code, a chip index, a bank, a row or column and a write byte mask. It turns the request into the pin pattern of an SDRAM command: clock enable, four active-low chip selects, RAS, CAS, write enable, a 4-bit byte mask and a 15-bit multiplexed address. Every output is registered on the memory clock, so a request presented before edge n appears on the pins right after edge n.

The block tracks the clock-enable level itself. Power-down and self-refresh are entered by dropping clock enable and left by raising it. While clock enable is low, only the exit request is legal. Any request that is illegal in the current state is rejected: the block raises a one-cycle error flag and puts a no-operation on the pins. The mode register word is built inside the block with burst length 1 and sequential bursts. One configuration bit selects a CAS latency of 2 or 3. Refresh scheduling, timing counters and the data path are outside this block.

The address layout is as follows. The bank sits in address bits 14:13. For an activate, the row sits in bits 12:0. For a read or write, the column sits in bits 9:0 and the auto-precharge flag in bit 10.

Top module: `sdr_cmd_issuer`

## Requirements
- R1: While rst_ni is low the pins hold the idle state: cke_o=1, cs_no=4'b1111, ras_no=cas_no=we_no=1, dqm_o=4'b1111, addr_o=0 and err_o=0.
- R2: In a cycle with req_valid_i low, the next pin state is the deselect no-operation (all selects, RAS, CAS and WE high, dqm_o=4'b1111, addr_o=0), and cke_o keeps its level. A valid request with code 0 (no-operation) while cke_o is high gives the same pins.
- R3: Activate (code 2) drives low only the select bit whose index equals req_chip_i. It also drives ras_no=0, cas_no=1, we_no=1 and dqm_o=4'b1111, with addr_o = {bank, row}.
- R4: Read (code 3) and read with auto-precharge (code 4) drive one select low by chip index. They drive ras_no=1, cas_no=0, we_no=1 and dqm_o=4'b0000. The address is bank in bits 14:13, column in bits 9:0, and bit 10 = 0 for code 3 or 1 for code 4; all other bits are 0.
- R5: Write (code 5) and write with auto-precharge (code 6) match R4, except that we_no=0 and dqm_o equals req_wmask_i.
- R6: Precharge all (code 7) drives all four selects low with ras_no=0, cas_no=1, we_no=0 and dqm_o=4'b1111. The address has only bit 10 set.
- R7: Auto-refresh (code 8) drives all four selects low with ras_no=0, cas_no=0, we_no=1, dqm_o=4'b0000 and addr_o=0.
- R8: Mode register set (code 1) drives all selects, RAS, CAS and WE low with dqm_o=4'b1111. The address is 15'h0020 when cas_lat3_i=0 and 15'h0030 when cas_lat3_i=1; the bits are latency in 6:4 (3'b01x), sequential burst in bit 3 = 0 and burst length 1 in bits 2:0 = 0.
- R9: Power-down entry (code 9) while cke_o is high drops cke_o to 0. It drives all selects, RAS, CAS and WE high with dqm_o=4'b1111.
- R10: Self-refresh entry (code 10) while cke_o is high drops cke_o to 0. It drives all selects low, ras_no=0, cas_no=0, we_no=1 and dqm_o=4'b0000.
- R11: Power-down exit (code 11) while cke_o is low raises cke_o to 1. It drives all selects, RAS, CAS and WE high with dqm_o=4'b1111.
- R12: While cke_o is low, a valid request with any code other than 11 raises err_o for one cycle. cke_o stays low and the pins keep the all-high pattern with dqm_o=4'b1111.
- R13: A valid request with code 11 while cke_o is high, or with a code of 12 to 15 in any state, raises err_o. The pins show the deselect no-operation and cke_o keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is present this cycle |
| req_op_i | input | 4 | Operation code (0 to 11) |
| req_chip_i | input | 2 | Target chip index |
| req_bank_i | input | 2 | Internal bank |
| req_row_i | input | 13 | Row address for activate |
| req_col_i | input | 10 | Column address for read and write |
| req_wmask_i | input | 4 | Byte mask for writes |
| cas_lat3_i | input | 1 | Mode latency select: 0 gives 2 cycles, 1 gives 3 |
| cke_o | output | 1 | Clock enable |
| cs_no | output | 4 | Chip selects, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| dqm_o | output | 4 | Byte mask lines |
| addr_o | output | 15 | Multiplexed address |
| err_o | output | 1 | Request rejected in the previous cycle |

## Verification
The assertions take the pin patterns as they come out of the registers. They assume the only clock-enable edges are the three legal ones, and that no other command ever appears while clock enable is low. The stimulus stays within what a scheduler may send: one request per cycle, with stable fields, applied away from the clock edge. It also walks every code, legal and illegal, in both clock-enable states. That way the rejection paths are driven on purpose and never by accident.

// File: rtl/sdr_cmd_pkg.sv
package sdr_cmd_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_MRS  = 4'd1,
    OP_ACT  = 4'd2,
    OP_RD   = 4'd3,
    OP_RDA  = 4'd4,
    OP_WR   = 4'd5,
    OP_WRA  = 4'd6,
    OP_PALL = 4'd7,
    OP_REF  = 4'd8,
    OP_PDN  = 4'd9,
    OP_SREF = 4'd10,
    OP_PDX  = 4'd11
  } sdr_op_e;

  localparam logic [3:0] OP_LAST = OP_PDX;

  typedef enum logic [1:0] {SEL_NONE, SEL_ONE, SEL_ALL} sel_kind_e;
  typedef enum logic [1:0] {MSK_OFF, MSK_ON, MSK_WR} msk_kind_e;
  typedef enum logic [2:0] {ADR_ZERO, ADR_ROW, ADR_COL, ADR_PALL, ADR_MODE} adr_kind_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdr_ctl_t;

  typedef struct packed {
    sdr_ctl_t  ctl;
    sel_kind_e sel;
    msk_kind_e msk;
    adr_kind_e adr;
    logic      ap;
  } sdr_dec_t;

  function automatic sdr_dec_t sdr_decode(sdr_op_e op);
    sdr_dec_t d;
    d = '{ctl: 3'b111, sel: SEL_NONE, msk: MSK_OFF, adr: ADR_ZERO, ap: 1'b0};
    case (op)
      OP_MRS:  d = '{ctl: 3'b000, sel: SEL_ALL, msk: MSK_OFF, adr: ADR_MODE, ap: 1'b0};
      OP_ACT:  d = '{ctl: 3'b011, sel: SEL_ONE, msk: MSK_OFF, adr: ADR_ROW,  ap: 1'b0};
      OP_RD:   d = '{ctl: 3'b101, sel: SEL_ONE, msk: MSK_ON,  adr: ADR_COL,  ap: 1'b0};
      OP_RDA:  d = '{ctl: 3'b101, sel: SEL_ONE, msk: MSK_ON,  adr: ADR_COL,  ap: 1'b1};
      OP_WR:   d = '{ctl: 3'b100, sel: SEL_ONE, msk: MSK_WR,  adr: ADR_COL,  ap: 1'b0};
      OP_WRA:  d = '{ctl: 3'b100, sel: SEL_ONE, msk: MSK_WR,  adr: ADR_COL,  ap: 1'b1};
      OP_PALL: d = '{ctl: 3'b010, sel: SEL_ALL, msk: MSK_OFF, adr: ADR_PALL, ap: 1'b0};
      OP_REF:  d = '{ctl: 3'b001, sel: SEL_ALL, msk: MSK_ON,  adr: ADR_ZERO, ap: 1'b0};
      OP_SREF: d = '{ctl: 3'b001, sel: SEL_ALL, msk: MSK_ON,  adr: ADR_ZERO, ap: 1'b0};
      default: ; // NOP, PDN, PDX: everything deasserted
    endcase
    return d;
  endfunction

endpackage

// File: rtl/sdr_cke_gate.sv
module sdr_cke_gate
  import sdr_cmd_pkg::*;
(
  input  logic       cke_q_i,
  input  logic       req_valid_i,
  input  logic [3:0] req_op_i,
  output sdr_op_e    eff_op_o,
  output logic       cke_nxt_o,
  output logic       reject_o
);

  always_comb begin
    eff_op_o  = OP_NOP;
    cke_nxt_o = cke_q_i;
    reject_o  = 1'b0;
    if (req_valid_i) begin
      if (req_op_i > OP_LAST) begin
        reject_o = 1'b1;
      end else if (!cke_q_i) begin
        if (req_op_i == OP_PDX) begin
          eff_op_o  = OP_PDX;
          cke_nxt_o = 1'b1;
        end else begin
          reject_o = 1'b1;
        end
      end else if (req_op_i == OP_PDX) begin
        reject_o = 1'b1;
      end else begin
        eff_op_o = sdr_op_e'(req_op_i);
        if (req_op_i == OP_PDN || req_op_i == OP_SREF) cke_nxt_o = 1'b0;
      end
    end
  end

endmodule

// File: rtl/sdr_addr_mux.sv
module sdr_addr_mux
  import sdr_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ROW_W  = 13,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned AP_BIT = 10
) (
  input  adr_kind_e          kind_i,
  input  logic               ap_i,
  input  logic [BANK_W-1:0]  bank_i,
  input  logic [ROW_W-1:0]   row_i,
  input  logic [COL_W-1:0]   col_i,
  input  logic               lat3_i,
  output logic [ADDR_W-1:0]  addr_o
);

  localparam int unsigned BANK_LSB = ADDR_W - BANK_W;
  localparam int unsigned MODE_W   = 7;

  always_comb begin
    addr_o = '0;
    case (kind_i)
      ADR_ROW: begin
        addr_o[BANK_LSB +: BANK_W] = bank_i;
        addr_o[ROW_W-1:0]          = row_i;
      end
      ADR_COL: begin
        addr_o[BANK_LSB +: BANK_W] = bank_i;
        addr_o[COL_W-1:0]          = col_i;
        addr_o[AP_BIT]             = ap_i;
      end
      ADR_PALL: addr_o[AP_BIT] = 1'b1;
      // latency {0,1,lat}, sequential, burst of one
      ADR_MODE: addr_o[MODE_W-1:0] = {1'b0, 1'b1, lat3_i, 1'b0, 3'b000};
      default: ;
    endcase
  end

endmodule

// File: rtl/sdr_pin_encode.sv
module sdr_pin_encode
  import sdr_cmd_pkg::*;
#(
  parameter int unsigned N_CHIPS = 4,
  parameter int unsigned MASK_W  = 4,
  localparam int unsigned CHIP_W = $clog2(N_CHIPS)
) (
  input  sel_kind_e          sel_i,
  input  msk_kind_e          msk_i,
  input  logic [CHIP_W-1:0]  chip_i,
  input  logic [MASK_W-1:0]  wmask_i,
  output logic [N_CHIPS-1:0] cs_n_o,
  output logic [MASK_W-1:0]  dqm_o
);

  for (genvar i = 0; i < N_CHIPS; i++) begin : g_cs
    always_comb begin
      case (sel_i)
        SEL_ALL: cs_n_o[i] = 1'b0;
        SEL_ONE: cs_n_o[i] = (chip_i != CHIP_W'(i));
        default: cs_n_o[i] = 1'b1;
      endcase
    end
  end

  always_comb begin
    case (msk_i)
      MSK_ON:  dqm_o = '0;
      MSK_WR:  dqm_o = wmask_i;
      default: dqm_o = '1;
    endcase
  end

endmodule

// File: rtl/sdr_cmd_issuer.sv
module sdr_cmd_issuer
  import sdr_cmd_pkg::*;
#(
  parameter int unsigned N_CHIPS = 4,
  parameter int unsigned MASK_W  = 4,
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned ROW_W   = 13,
  parameter int unsigned COL_W   = 10,
  parameter int unsigned AP_BIT  = 10,
  localparam int unsigned CHIP_W = $clog2(N_CHIPS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [3:0]         req_op_i,
  input  logic [CHIP_W-1:0]  req_chip_i,
  input  logic [BANK_W-1:0]  req_bank_i,
  input  logic [ROW_W-1:0]   req_row_i,
  input  logic [COL_W-1:0]   req_col_i,
  input  logic [MASK_W-1:0]  req_wmask_i,
  input  logic               cas_lat3_i,
  output logic               cke_o,
  output logic [N_CHIPS-1:0] cs_no,
  output logic               ras_no,
  output logic               cas_no,
  output logic               we_no,
  output logic [MASK_W-1:0]  dqm_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               err_o
);

  sdr_op_e             eff_op;
  logic                cke_nxt, reject;
  sdr_dec_t            dec;
  logic [N_CHIPS-1:0]  cs_n_d;
  logic [MASK_W-1:0]   dqm_d;
  logic [ADDR_W-1:0]   addr_d;

  sdr_cke_gate u_gate (
    .cke_q_i     (cke_o),
    .req_valid_i (req_valid_i),
    .req_op_i    (req_op_i),
    .eff_op_o    (eff_op),
    .cke_nxt_o   (cke_nxt),
    .reject_o    (reject)
  );

  assign dec = sdr_decode(eff_op);

  sdr_pin_encode #(.N_CHIPS(N_CHIPS), .MASK_W(MASK_W)) u_enc (
    .sel_i   (dec.sel),
    .msk_i   (dec.msk),
    .chip_i  (req_chip_i),
    .wmask_i (req_wmask_i),
    .cs_n_o  (cs_n_d),
    .dqm_o   (dqm_d)
  );

  sdr_addr_mux #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT)
  ) u_amux (
    .kind_i (dec.adr),
    .ap_i   (dec.ap),
    .bank_i (req_bank_i),
    .row_i  (req_row_i),
    .col_i  (req_col_i),
    .lat3_i (cas_lat3_i),
    .addr_o (addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_o  <= 1'b1;
      cs_no  <= '1;
      ras_no <= 1'b1;
      cas_no <= 1'b1;
      we_no  <= 1'b1;
      dqm_o  <= '1;
      addr_o <= '0;
      err_o  <= 1'b0;
    end else begin
      cke_o  <= cke_nxt;
      cs_no  <= cs_n_d;
      ras_no <= dec.ctl.ras_n;
      cas_no <= dec.ctl.cas_n;
      we_no  <= dec.ctl.we_n;
      dqm_o  <= dqm_d;
      addr_o <= addr_d;
      err_o  <= reject;
    end
  end

endmodule

// File: rtl/sdr_cmd_issuer_chk.sv
module sdr_cmd_issuer_chk #(
  parameter int unsigned N_CHIPS = 4,
  parameter int unsigned MASK_W  = 4,
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned AP_BIT  = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cke_o,
  input logic [N_CHIPS-1:0] cs_no,
  input logic               ras_no,
  input logic               cas_no,
  input logic               we_no,
  input logic [MASK_W-1:0]  dqm_o,
  input logic [ADDR_W-1:0]  addr_o,
  input logic               err_o
);

  logic quiet;
  assign quiet = (&cs_no) && ras_no && cas_no && we_no && (&dqm_o);

  a_r9_r10_cke_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> quiet ||
      (cs_no == '0 && !ras_no && !cas_no && we_no && dqm_o == '0));

  a_r11_cke_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> quiet);

  a_r12_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && !$fell(cke_o)) |-> quiet);

  a_r3_act_one_chip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_no && cas_no && we_no) |-> ($onehot(~cs_no) && (&dqm_o)));

  a_r6_pall_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_no && cas_no && !we_no) |-> (cs_no == '0 && addr_o[AP_BIT]));

  a_r13_err_no_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ((&cs_no) && ras_no && cas_no && we_no));

  a_r12_err_keeps_cke: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cke_o == $past(cke_o)));

endmodule

bind sdr_cmd_issuer sdr_cmd_issuer_chk #(
  .N_CHIPS(N_CHIPS), .MASK_W(MASK_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cke_o  (cke_o),
  .cs_no  (cs_no),
  .ras_no (ras_no),
  .cas_no (cas_no),
  .we_no  (we_no),
  .dqm_o  (dqm_o),
  .addr_o (addr_o),
  .err_o  (err_o)
);

// File: tb/sdr_cmd_issuer_tb.sv
module sdr_cmd_issuer_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_op = '0;
  logic [1:0]  req_chip = '0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic [3:0]  req_wmask = '0;
  logic        lat3 = 1'b0;
  logic        cke, ras_n, cas_n, we_n, err;
  logic [3:0]  cs_n, dqm;
  logic [14:0] addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic cke_m = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_cmd_issuer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_chip_i(req_chip), .req_bank_i(req_bank), .req_row_i(req_row),
    .req_col_i(req_col), .req_wmask_i(req_wmask), .cas_lat3_i(lat3),
    .cke_o(cke), .cs_no(cs_n), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n),
    .dqm_o(dqm), .addr_o(addr), .err_o(err)
  );

  // {cke, cs_n, ras, cas, we, dqm, addr, err}
  function automatic logic [28:0] pins();
    return {cke, cs_n, ras_n, cas_n, we_n, dqm, addr, err};
  endfunction

  task automatic compare(input logic [28:0] exp, input string req);
    checks++;
    if (pins() !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, pins(), exp);
    end
  endtask

  task automatic step(input logic v, input int op, input int chip, input int bank,
                      input int row, input int col, input int mask, input int lat,
                      input string req);
    logic e_cke, e_ras, e_cas, e_we, e_err;
    logic [3:0] e_cs, e_dqm, one_cs;
    logic [14:0] e_addr;
    @(negedge clk);
    req_valid = v; req_op = 4'(op); req_chip = 2'(chip); req_bank = 2'(bank);
    req_row = 13'(row); req_col = 10'(col); req_wmask = 4'(mask); lat3 = lat[0];
    e_cke = cke_m; e_cs = 4'hF; e_ras = 1; e_cas = 1; e_we = 1;
    e_dqm = 4'hF; e_addr = '0; e_err = 0;
    one_cs = ~(4'b0001 << chip);
    if (v) begin
      if (op > 11 || (!cke_m && op != 11) || (cke_m && op == 11)) e_err = 1;
      else case (op)
        1: begin e_cs = 0; e_ras = 0; e_cas = 0; e_we = 0; e_addr = 15'(32 + 16 * lat); end
        2: begin e_cs = one_cs; e_ras = 0; e_addr = 15'(bank * 8192 + row); end
        3, 4: begin
          e_cs = one_cs; e_cas = 0; e_dqm = 0;
          e_addr = 15'(bank * 8192 + col + (op == 4 ? 1024 : 0));
        end
        5, 6: begin
          e_cs = one_cs; e_cas = 0; e_we = 0; e_dqm = 4'(mask);
          e_addr = 15'(bank * 8192 + col + (op == 6 ? 1024 : 0));
        end
        7: begin e_cs = 0; e_ras = 0; e_we = 0; e_addr = 15'd1024; end
        8: begin e_cs = 0; e_ras = 0; e_cas = 0; e_dqm = 0; end
        9: e_cke = 0;
        10: begin e_cke = 0; e_cs = 0; e_ras = 0; e_cas = 0; e_dqm = 0; end
        11: e_cke = 1;
        default: ;
      endcase
    end
    cke_m = e_cke;
    @(posedge clk);
    #(CLK_PERIOD/4);
    compare({e_cke, e_cs, e_ras, e_cas, e_we, e_dqm, e_addr, e_err}, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    compare({1'b1, 4'hF, 3'b111, 4'hF, 15'd0, 1'b0}, "R1");
    @(negedge clk);
    rst_n = 1'b1;

    // R2: idle and explicit no-operation
    for (int k = 0; k < 3; k++) step(0, 2, k, k, 7, 7, 0, 0, "R2");
    step(1, 0, 1, 1, 5, 5, 0, 0, "R2");

    // R3: activate sweep
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 4; b++)
        for (int r = 0; r < 3; r++)
          step(1, 2, c, b, (r == 0) ? 0 : (r == 1) ? 13'h1FFF : 13'h0A5A, 0, 0, 0, "R3");

    // R4: reads with and without auto-precharge
    for (int c = 0; c < 4; c++)
      for (int ap = 0; ap < 2; ap++)
        for (int k = 0; k < 3; k++)
          step(1, 3 + ap, c, (c + k) % 4, 0, (k == 0) ? 0 : (k == 1) ? 10'h3FF : 10'h155,
               4'hA, 0, "R4");

    // R5: writes over every mask
    for (int m = 0; m < 16; m++)
      for (int ap = 0; ap < 2; ap++)
        step(1, 5 + ap, m % 4, 3 - (m % 4), 0, m * 61, m, 0, "R5");

    step(1, 7, 2, 1, 0, 0, 0, 0, "R6");
    step(1, 8, 3, 0, 0, 0, 0, 0, "R7");
    step(1, 1, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 1, 1, 2, 99, 99, 5, 1, "R8");

    // R9, R11, R12: power-down cycle with every other code rejected
    step(1, 9, 0, 0, 0, 0, 0, 0, "R9");
    for (int op = 0; op < 16; op++)
      if (op != 11) step(1, op, op % 4, 1, 3, 3, 0, 0, "R12");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R12");
    step(1, 11, 0, 0, 0, 0, 0, 0, "R11");

    // R10: self-refresh, rejected read, exit, no-operation
    step(1, 10, 1, 0, 0, 0, 0, 0, "R10");
    step(1, 3, 1, 0, 0, 4, 0, 0, "R12");
    step(1, 11, 0, 0, 0, 0, 0, 0, "R11");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R2");

    // R13: exit while awake and out-of-range codes
    step(1, 11, 0, 0, 0, 0, 0, 0, "R13");
    for (int op = 12; op < 16; op++) step(1, op, 2, 2, 9, 9, 3, 1, "R13");
    step(1, 2, 1, 3, 13'h1234, 0, 0, 0, "R3");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule